// File: doc/BRIEF.md
# Video Timing Output Conditioner

This block sits at the output edge of a video decoder and conditions the raw timing strobes produced inside the decoder before they leave the chip. It registers the horizontal sync, vertical sync, blanking, field, valid-pixel and vertical-interval-data strobes in the pixel clock domain. It then gives each one a programmable active level and drives output-enable flags for the pixel data bus and for the timing group.

The valid-pixel output is built by its own generator, whose behaviour depends on the output format. The wide (16-bit) formats give a half-rate toggle, a line-lock driven strobe, or a strobe that covers the whole line. The narrow (8-bit and BT.656) formats pass the active-video strobe straight through, optionally gated by the level of a second clock. A freeze request stops all timing outputs at a field end and lets them run again only at a later field start. Register values arrive as plain input ports and are captured inside the block.

Top module: `vid_timing_cond`

## Requirements
- R1: Configuration inputs are captured on every clock edge and take effect from the cycle after they are sampled. In `out_cfg_i`, bits 0..5 are the polarities of hsync, vsync, blank, field, dvalid and vbivalid. A polarity bit of 1 drives the output equal to its registered strobe, and 0 drives the inverted strobe.
- R2: Each timing output reflects the strobe that was sampled on the previous rising clock edge, so there is one cycle of latency.
- R3: While reset is held, both output enables are 0. Every timing output is then 1, because all strobes and polarities read as 0.
- R4: `out_cfg_i` bit 7 drives `data_oe_o` and bit 6 drives `timing_oe_o`, each one cycle after it is sampled.
- R5: In the wide modes (`mode_i` = 2 or 3) with `gen_cfg_i` bits 1 and 2 at 0, the internal dvalid is 0 while the active strobe is low. While the active strobe is high, dvalid alternates 1,0,1,0, starting with 1 on the first active cycle.
- R6: In the wide modes with `gen_cfg_i` bit 1 at 1, dvalid inside the window follows the line-lock strobe and is 0 outside the window.
- R7: In the wide modes with `gen_cfg_i` bit 2 at 1, the window is open on every cycle regardless of the active strobe.
- R8: In the narrow modes (`mode_i` = 0 or 1), dvalid follows the active strobe, and `gen_cfg_i` bit 1 has no effect.
- R9: In the narrow modes with `gen_cfg_i` bit 2 at 1, the internal dvalid is ANDed with `clk2_i` without any register stage. The AND is applied before the polarity.
- R10: If `gen_cfg_i` bit 0 is 1 when an end-of-field strobe arrives, the strobes of that cycle are captured. After that, all timing outputs hold their values.
- R11: While the block is frozen and the freeze bit is 0, a start-of-field strobe releases the freeze, and the strobes of that same cycle are captured.
- R12: A freeze bit with no end-of-field strobe has no effect. A cleared freeze bit with no start-of-field strobe keeps the outputs frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_cfg_i | input | 8 | Polarity bits 0..5, timing enable bit 6, data enable bit 7 |
| gen_cfg_i | input | 3 | Bit 0 freeze request, bit 1 line-lock dvalid, bit 2 whole-line / clk2 gating |
| mode_i | input | 2 | Output format: 0 8-bit, 1 BT.656, 2 and 3 16-bit |
| hs_raw_i | input | 1 | Internal horizontal sync strobe |
| vs_raw_i | input | 1 | Internal vertical sync strobe |
| blank_raw_i | input | 1 | Internal blanking strobe |
| field_raw_i | input | 1 | Internal odd-field strobe |
| vbi_raw_i | input | 1 | Internal vertical-interval data strobe |
| act_raw_i | input | 1 | Active video on an active line |
| lock_raw_i | input | 1 | Line-lock pixel strobe |
| clk2_i | input | 1 | Level of the double-rate clock, used as data |
| sof_i | input | 1 | Start-of-field strobe |
| eof_i | input | 1 | End-of-field strobe |
| hsync_o | output | 1 | Conditioned horizontal sync |
| vsync_o | output | 1 | Conditioned vertical sync |
| blank_o | output | 1 | Conditioned blanking |
| field_o | output | 1 | Conditioned field |
| dvalid_o | output | 1 | Conditioned valid-pixel strobe |
| vbivalid_o | output | 1 | Conditioned vertical-interval data strobe |
| data_oe_o | output | 1 | Drive enable for the pixel data bus |
| timing_oe_o | output | 1 | Drive enable for the timing group |

## Verification
Strobe results appear exactly one rising edge after they are driven. The bench drives every input one nanosecond after an edge and reads the outputs one nanosecond after the following edge. Configuration changes pass through one extra register stage, so the bench lets at least two edges go by after each change before it judges anything. The `clk2_i` gating is the only path with no register, and it is checked within the same cycle, after a short settle. Freeze entry and release are judged on the edge that samples the field strobe and on the three edges after it.

// File: rtl/vto_pkg.sv
package vto_pkg;
  localparam int CFG_W      = 8;
  localparam int NSIG       = 6;
  localparam int IDX_HS     = 0;
  localparam int IDX_VS     = 1;
  localparam int IDX_BLANK  = 2;
  localparam int IDX_FIELD  = 3;
  localparam int IDX_DV     = 4;
  localparam int IDX_VBI    = 5;
  localparam int OE_TIM_BIT = 6;
  localparam int OE_DAT_BIT = 7;

  typedef enum logic [1:0] {
    MODE_YC8      = 2'd0,
    MODE_BT656    = 2'd1,
    MODE_WIDE     = 2'd2,
    MODE_WIDE_ALT = 2'd3
  } out_mode_e;

  typedef struct packed {
    logic line_all;
    logic dv_lock;
    logic freeze;
  } gen_cfg_t;
endpackage

// File: rtl/vto_cfg_reg.sv
module vto_cfg_reg
  import vto_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] out_cfg_i,
  input  gen_cfg_t     gen_cfg_i,
  input  out_mode_e    mode_i,
  output logic [W-1:0] out_cfg_q,
  output gen_cfg_t     gen_cfg_q,
  output out_mode_e    mode_q
);
  logic [W-1:0] out_d;
  gen_cfg_t     gen_d;
  out_mode_e    mode_d;

  always_comb begin
    out_d  = out_cfg_i;
    gen_d  = gen_cfg_i;
    mode_d = mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cfg_q <= '0;
      gen_cfg_q <= '0;
      mode_q    <= MODE_YC8;
    end else begin
      out_cfg_q <= out_d;
      gen_cfg_q <= gen_d;
      mode_q    <= mode_d;
    end
  end
endmodule

// File: rtl/vto_freeze.sv
module vto_freeze (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic sof_i,
  input  logic eof_i,
  output logic frozen_o,
  output logic upd_o
);
  logic frz_q, frz_d;
  logic enter, leave;

  always_comb begin
    enter = !frz_q && eof_i && req_i;
    leave = frz_q && sof_i && !req_i;
    frz_d = frz_q;
    if (enter)      frz_d = 1'b1;
    else if (leave) frz_d = 1'b0;
    upd_o = !frz_q || leave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_q <= 1'b0;
    else        frz_q <= frz_d;
  end

  assign frozen_o = frz_q;

  p_entry_on_eof_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_q) |-> ($past(eof_i) && $past(req_i)));

  p_exit_on_sof_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frz_q) |-> ($past(sof_i) && !$past(req_i)));
endmodule

// File: rtl/vto_dvalid.sv
module vto_dvalid (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic wide_i,
  input  logic dv_lock_i,
  input  logic line_all_i,
  input  logic act_i,
  input  logic lock_i,
  output logic dv_o
);
  logic dv_q, dv_d;
  logic tgl_q, tgl_d;
  logic win;
  logic toggle_mode;

  always_comb begin
    win         = line_all_i || act_i;
    toggle_mode = wide_i && !dv_lock_i;
    tgl_d       = 1'b0;
    if (!wide_i) begin
      dv_d = act_i;
    end else if (dv_lock_i) begin
      dv_d = win && lock_i;
    end else begin
      dv_d  = win && !tgl_q;
      tgl_d = win ? !tgl_q : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      tgl_q <= 1'b0;
    end else if (en_i) begin
      dv_q  <= dv_d;
      tgl_q <= tgl_d;
    end
  end

  assign dv_o = dv_q;

  p_half_rate_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && toggle_mode && dv_q && $past(en_i && toggle_mode)) |=> !dv_q);
endmodule

// File: rtl/vto_pol_out.sv
module vto_pol_out #(
  parameter int N = 6
) (
  input  logic [N-1:0] val_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] out_o
);
  for (genvar i = 0; i < N; i++) begin : g_pol
    assign out_o[i] = pol_i[i] ? val_i[i] : !val_i[i];
  end
endmodule

// File: rtl/vid_timing_cond.sv
module vid_timing_cond
  import vto_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] out_cfg_i,
  input  logic [2:0] gen_cfg_i,
  input  logic [1:0] mode_i,
  input  logic       hs_raw_i,
  input  logic       vs_raw_i,
  input  logic       blank_raw_i,
  input  logic       field_raw_i,
  input  logic       vbi_raw_i,
  input  logic       act_raw_i,
  input  logic       lock_raw_i,
  input  logic       clk2_i,
  input  logic       sof_i,
  input  logic       eof_i,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       blank_o,
  output logic       field_o,
  output logic       dvalid_o,
  output logic       vbivalid_o,
  output logic       data_oe_o,
  output logic       timing_oe_o
);
  logic [CFG_W-1:0] ocfg_q;
  gen_cfg_t         gcfg_q;
  out_mode_e        mode_q;
  logic             frozen, upd;
  logic             wide;
  logic             dv_q;
  logic [NSIG-1:0]  raw_d, tim_q, tim_vec, out_vec;

  vto_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_cfg_i (out_cfg_i),
    .gen_cfg_i (gen_cfg_t'(gen_cfg_i)),
    .mode_i    (out_mode_e'(mode_i)),
    .out_cfg_q (ocfg_q),
    .gen_cfg_q (gcfg_q),
    .mode_q    (mode_q)
  );

  vto_freeze u_frz (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (gcfg_q.freeze),
    .sof_i    (sof_i),
    .eof_i    (eof_i),
    .frozen_o (frozen),
    .upd_o    (upd)
  );

  assign wide = (mode_q == MODE_WIDE) || (mode_q == MODE_WIDE_ALT);

  vto_dvalid u_dv (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (upd),
    .wide_i     (wide),
    .dv_lock_i  (gcfg_q.dv_lock),
    .line_all_i (gcfg_q.line_all),
    .act_i      (act_raw_i),
    .lock_i     (lock_raw_i),
    .dv_o       (dv_q)
  );

  always_comb begin
    raw_d            = tim_q;
    raw_d[IDX_HS]    = hs_raw_i;
    raw_d[IDX_VS]    = vs_raw_i;
    raw_d[IDX_BLANK] = blank_raw_i;
    raw_d[IDX_FIELD] = field_raw_i;
    raw_d[IDX_VBI]   = vbi_raw_i;
    raw_d[IDX_DV]    = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tim_q <= '0;
    else if (upd) tim_q <= raw_d;
  end

  always_comb begin
    tim_vec         = tim_q;
    tim_vec[IDX_DV] = dv_q && (wide || !gcfg_q.line_all || clk2_i);
  end

  vto_pol_out #(.N(NSIG)) u_pol (
    .val_i (tim_vec),
    .pol_i (ocfg_q[NSIG-1:0]),
    .out_o (out_vec)
  );

  assign hsync_o     = out_vec[IDX_HS];
  assign vsync_o     = out_vec[IDX_VS];
  assign blank_o     = out_vec[IDX_BLANK];
  assign field_o     = out_vec[IDX_FIELD];
  assign dvalid_o    = out_vec[IDX_DV];
  assign vbivalid_o  = out_vec[IDX_VBI];
  assign data_oe_o   = ocfg_q[OE_DAT_BIT];
  assign timing_oe_o = ocfg_q[OE_TIM_BIT];

  p_hold_while_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !upd) |=> ($stable(tim_q) && $stable(dv_q)));

  p_strobe_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && $past(!frozen)) |-> (tim_q[IDX_HS] == $past(hs_raw_i)));
endmodule

// File: tb/vid_timing_cond_bench.sv
`timescale 1ns/1ps
module vid_timing_cond_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] out_cfg;
  logic [2:0] gen_cfg;
  logic [1:0] mode;
  logic hs, vs, blank, field, vbi, act, lock, clk2, sof, eof;
  logic hsync_o, vsync_o, blank_o, field_o, dvalid_o, vbivalid_o, data_oe_o, timing_oe_o;
  int runs = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vid_timing_cond u_vid_timing_cond (
    .clk(clk), .rst_n(rst_n), .out_cfg_i(out_cfg), .gen_cfg_i(gen_cfg), .mode_i(mode),
    .hs_raw_i(hs), .vs_raw_i(vs), .blank_raw_i(blank), .field_raw_i(field),
    .vbi_raw_i(vbi), .act_raw_i(act), .lock_raw_i(lock), .clk2_i(clk2),
    .sof_i(sof), .eof_i(eof), .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o),
    .field_o(field_o), .dvalid_o(dvalid_o), .vbivalid_o(vbivalid_o),
    .data_oe_o(data_oe_o), .timing_oe_o(timing_oe_o));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act_v, input logic [7:0] exp_v);
    runs++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  function automatic logic [5:0] outs();
    return {vbivalid_o, dvalid_o, field_o, blank_o, vsync_o, hsync_o};
  endfunction

  task automatic set_raw(input logic [5:0] s);
    {vbi, act, field, blank, vs, hs} = s;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; out_cfg = 8'h00; gen_cfg = 3'b000; mode = 2'd0;
    hs = 0; vs = 0; blank = 0; field = 0; vbi = 0; act = 0; lock = 0; clk2 = 0; sof = 0; eof = 0;
    out_cfg = 8'hFF; gen_cfg = 3'b111; mode = 2'd2;
    repeat (3) tick();
    // R3: reset state holds regardless of configuration inputs
    check("R3 oe", {6'd0, data_oe_o, timing_oe_o}, 8'h00);
    check("R3 outs", {2'd0, outs()}, 8'h3F);
    rst_n = 1'b1;
    out_cfg = 8'h00; gen_cfg = 3'b000; mode = 2'd0;
    repeat (2) tick();

    // R4: enable bits, one cycle after sampling
    for (int e = 0; e < 4; e++) begin
      out_cfg = {e[1], e[0], 6'd0};
      tick();
      check("R4 oe", {6'd0, data_oe_o, timing_oe_o}, {6'd0, e[1], e[0]});
    end

    // R1/R2/R8: exhaustive polarity x strobe sweep (narrow mode, dvalid = act)
    for (int p = 0; p < 64; p++) begin
      out_cfg = {2'b00, p[5:0]};
      tick();
      for (int s = 0; s < 64; s++) begin
        set_raw(s[5:0]);
        tick();
        check("R1 R2 polarity", {2'd0, outs()}, {2'd0, p[5:0] ~^ s[5:0]});
      end
    end

    // R8: duty bit ignored in narrow modes, both narrow modes
    out_cfg = 8'h10; set_raw(6'd0);
    for (int m = 0; m < 2; m++) begin
      mode = m[1:0]; gen_cfg = 3'b010; lock = 1'b0;
      repeat (2) tick();
      for (int k = 0; k < 6; k++) begin
        act = k[0]; tick();
        check("R8 narrow dv", {7'd0, dvalid_o}, {7'd0, k[0]});
      end
    end

    // R9: clk2 gating, no register
    mode = 2'd0; gen_cfg = 3'b100; act = 1'b1; clk2 = 1'b0;
    repeat (2) tick();
    check("R9 clk2 low", {7'd0, dvalid_o}, 8'd0);
    clk2 = 1'b1; #1;
    check("R9 clk2 high", {7'd0, dvalid_o}, 8'd1);
    clk2 = 1'b0; #1;
    check("R9 clk2 low again", {7'd0, dvalid_o}, 8'd0);

    // R5: wide half-rate toggle within active window
    mode = 2'd2; gen_cfg = 3'b000; act = 1'b0;
    repeat (3) tick();
    check("R5 outside window", {7'd0, dvalid_o}, 8'd0);
    act = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R5 toggle", {7'd0, dvalid_o}, {7'd0, ~k[0]});
    end
    act = 1'b0; tick();
    check("R5 window closed", {7'd0, dvalid_o}, 8'd0);

    // R6: line-lock driven, mode 3
    mode = 2'd3; gen_cfg = 3'b010; act = 1'b1;
    repeat (2) tick();
    for (int k = 0; k < 8; k++) begin
      lock = k[1]; tick();
      check("R6 lock in window", {7'd0, dvalid_o}, {7'd0, k[1]});
    end
    act = 1'b0; lock = 1'b1; tick();
    check("R6 lock outside window", {7'd0, dvalid_o}, 8'd0);

    // R7: whole line
    gen_cfg = 3'b110; act = 1'b0; lock = 1'b1;
    repeat (2) tick();
    check("R7 whole line lock", {7'd0, dvalid_o}, 8'd1);
    gen_cfg = 3'b100;
    repeat (2) tick();
    begin
      logic prev;
      prev = dvalid_o;
      for (int k = 0; k < 6; k++) begin
        tick();
        check("R7 whole line toggle", {7'd0, dvalid_o}, {7'd0, ~prev});
        prev = dvalid_o;
      end
    end

    // R10..R12: freeze / release
    mode = 2'd0; gen_cfg = 3'b001; out_cfg = 8'h01; lock = 0; set_raw(6'd0);
    repeat (2) tick();
    hs = 1'b1; tick();
    check("R12 freeze bit without eof", {7'd0, hsync_o}, 8'd1);
    hs = 1'b0; eof = 1'b1; tick();
    check("R10 eof cycle captured", {7'd0, hsync_o}, 8'd0);
    eof = 1'b0; hs = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R10 hold while frozen", {7'd0, hsync_o}, 8'd0);
    end
    gen_cfg = 3'b000;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R12 cleared without sof", {7'd0, hsync_o}, 8'd0);
    end
    sof = 1'b1; tick();
    check("R11 sof cycle captured", {7'd0, hsync_o}, 8'd1);
    sof = 1'b0; hs = 1'b0; tick();
    check("R11 running again", {7'd0, hsync_o}, 8'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule